// File: doc/BRIEF.md
# Tracking Thermistor ADC Controller

This block is the digital side of a tracking converter that measures printhead temperature. An external comparator decides whether the thermistor voltage lies above or below the voltage of an external 6-bit DAC. On every counter-clock pulse, the block moves a 9-bit up/down count one step in the direction that comparator asks for. The upper six bits of the count drive the DAC, so the analog loop closes through this block.

The lower three bits of the count act as a filter. The DAC code changes only after several steps in the same direction, so comparator noise around the trip point does not make the DAC code jitter. The count saturates at both ends. A ready flag reports that the loop has settled: the DAC code has stayed the same for a programmable number of steps. The CPU reads the code and the flag from one data word.

Top module: `thermo_track_adc`

## Requirements
- R1: After reset the count is mid-scale (256). So `dac_code` is 32, `code_valid` is 0 and `rd_data` is 8'h20.
- R2: On a clock edge with `step_tick` high, the count goes up by one if the synchronised comparator is high and down by one if it is low. With `step_tick` low, the count holds whatever the comparator does.
- R3: The count never wraps. An up step at 511 leaves it at 511, and a down step at 0 leaves it at 0.
- R4: `dac_code` always equals bits 8..3 of the count. It changes only when the count crosses a multiple of 8.
- R5: `cmp_above` passes through two flip-flops before it is used. A step taken on clock edge k uses the value `cmp_above` had at edge k-2.
- R6: `code_valid` rises on the step that makes the count of consecutive steps leaving `dac_code` unchanged reach `settle_len`. It falls on any step that changes `dac_code`.
- R7: `rd_data` is laid out as follows: bit 7 is `code_valid`, bit 6 is zero and bits 5..0 are `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_tick | input | 1 | Counter-clock pulse, one clock wide per step |
| cmp_above | input | 1 | Asynchronous comparator output: thermistor above DAC |
| settle_len | input | 8 | Number of unchanged steps needed before the code is flagged valid |
| dac_code | output | 6 | Code driven to the external DAC |
| code_valid | output | 1 | Settled flag |
| rd_data | output | 8 | CPU-readable word holding the flag and the code |

## Verification
A step changes the count, `dac_code`, `code_valid` and `rd_data` on the same clock edge where `step_tick` is high. The bench therefore drives its inputs and samples the outputs on falling edges, and it reads the results one half-cycle after the last step. A new comparator level takes effect only two edges after it is applied. For this reason the table walk waits three idle clocks after each comparator change. A directed test then steps right away, to confirm that exactly two stale decisions are used. After `rst_n` is released, the bench waits several clocks so that the internal reset synchroniser has released before any step is issued.

// File: rtl/ttadc_pkg.sv
package ttadc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/ttadc_sync2.sv
module ttadc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_q == $past(meta_q)); // R5
endmodule

// File: rtl/ttadc_counter.sv
module ttadc_counter
  import ttadc_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  step_dir_e        dir,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W - 1);

  always_comb begin
    cnt_d = cnt_q;
    if (step_en) begin
      if (dir == DIR_UP) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MID;
    else if (step_en) cnt_q <= cnt_d;
  end

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && dir == DIR_UP && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R3
  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && dir == DIR_DOWN && cnt_q == '0) |=> cnt_q == '0); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt_q)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && dir == DIR_UP && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && dir == DIR_DOWN && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
endmodule

// File: rtl/ttadc_settle.sv
module ttadc_settle #(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic [CODE_W-1:0]   code_cur,
  input  logic [CODE_W-1:0]   code_nxt,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                valid
);
  localparam logic [SETTLE_W-1:0] RUN_MAX = {SETTLE_W{1'b1}};

  logic [SETTLE_W-1:0] run_q, run_d;
  logic                valid_q, valid_d;

  always_comb begin
    run_d   = run_q;
    valid_d = valid_q;
    if (step_en) begin
      if (code_nxt != code_cur) begin
        run_d   = '0;
        valid_d = 1'b0;
      end else begin
        run_d   = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        valid_d = (run_d >= settle_len);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      valid_q <= 1'b0;
    end else if (step_en) begin
      run_q   <= run_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;

  AST_VALID_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> run_q >= settle_len || $past(valid_q)); // R6
endmodule

// File: rtl/thermo_track_adc.sv
module thermo_track_adc
  import ttadc_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int DAC_W    = 6,
  parameter int SETTLE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_tick,
  input  logic               cmp_above,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic [DAC_W-1:0]   dac_code,
  output logic               code_valid,
  output logic [DAC_W+1:0]   rd_data
);
  localparam int FILT_W = CNT_W - DAC_W;

  logic             rst_meta_q, rst_sync_q;
  logic             cmp_s;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  step_dir_e        dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ttadc_sync2 i_cmp_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .async_in (cmp_above),
    .sync_out (cmp_s)
  );

  assign dir = cmp_s ? DIR_UP : DIR_DOWN;

  ttadc_counter #(.CNT_W(CNT_W)) i_counter (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .step_en (step_tick),
    .dir     (dir),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d)
  );

  ttadc_settle #(.CODE_W(DAC_W), .SETTLE_W(SETTLE_W)) i_settle (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .step_en    (step_tick),
    .code_cur   (cnt_q[CNT_W-1:FILT_W]),
    .code_nxt   (cnt_d[CNT_W-1:FILT_W]),
    .settle_len (settle_len),
    .valid      (code_valid)
  );

  assign dac_code = cnt_q[CNT_W-1:FILT_W];
  assign rd_data  = {code_valid, 1'b0, dac_code};

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (dac_code != $past(dac_code)) |-> !code_valid); // R6
  AST_CODE_FILTERED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (dac_code != $past(dac_code)) |-> cnt_q[FILT_W-1:0] == '0 || cnt_q[FILT_W-1:0] == '1); // R4
  AST_READ_LAYOUT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rd_data[DAC_W] == 1'b0 && rd_data[DAC_W+1] == code_valid); // R7
endmodule

// File: tb/test_thermo_track_adc.sv
module test_thermo_track_adc;
  logic       clk;
  logic       rst_n;
  logic       step_tick;
  logic       cmp_above;
  logic [7:0] settle_len;
  logic [5:0] dac_code;
  logic       code_valid;
  logic [7:0] rd_data;

  int checks;
  int errors;
  bit done;

  localparam int NVEC = 5;
  localparam int V_UP  [NVEC] = '{1, 0, 1, 1, 0};
  localparam int V_N   [NVEC] = '{8, 16, 3, 5, 7};
  localparam int V_CODE[NVEC] = '{33, 31, 31, 32, 31};

  thermo_track_adc i_thermo_track_adc (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_tick  (step_tick),
    .cmp_above  (cmp_above),
    .settle_len (settle_len),
    .dac_code   (dac_code),
    .code_valid (code_valid),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic steps(input int n);
    step_tick = 1'b1;
    repeat (n) @(negedge clk);
    step_tick = 1'b0;
  endtask

  task automatic set_cmp(input logic v);
    cmp_above = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    step_tick = 1'b0;
    cmp_above = 1'b0;
    settle_len = 8'd4;
    do_reset();

    // R1 reset state
    check("R1 dac_code", dac_code, 32);
    check("R1 code_valid", code_valid, 0);
    check("R7 rd_data after reset", rd_data, 'h20);

    // R5: comparator raised on the same edge as stepping starts; 2 stale downs, 9 ups -> 263
    @(negedge clk);
    cmp_above = 1'b1;
    steps(11);
    check("R5 two-stage sync count", dac_code, 32);
    steps(1);  // 264 -> code 33 only if exactly two stale decisions were used
    check("R5 two-stage sync boundary", dac_code, 33);

    // R6/R7 settle flag
    do_reset();
    settle_len = 8'd4;
    set_cmp(1'b1);
    steps(3);
    check("R6 not yet settled", code_valid, 0);
    steps(1);
    check("R6 settled after 4 steps", code_valid, 1);
    check("R7 rd_data valid word", rd_data, 'h80 | 32);
    steps(4);
    check("R6 cleared on code change", code_valid, 0);
    check("R4 code after crossing", dac_code, 33);

    // table walk R2/R4
    do_reset();
    settle_len = 8'd255;
    for (int i = 0; i < NVEC; i++) begin
      set_cmp(V_UP[i] != 0);
      steps(V_N[i]);
      check($sformatf("R2 R4 vector %0d", i), dac_code, V_CODE[i]);
    end
    // count now 249

    // R3 saturation
    set_cmp(1'b1);
    steps(300);
    check("R3 top saturation", dac_code, 63);
    set_cmp(1'b0);
    steps(1);
    check("R3 one below top", dac_code, 63);
    set_cmp(1'b1);
    steps(5);
    check("R3 held at top", dac_code, 63);
    set_cmp(1'b0);
    steps(600);
    check("R3 bottom saturation", dac_code, 0);
    set_cmp(1'b1);
    steps(1);
    check("R3 up from bottom", dac_code, 0);
    steps(7);
    check("R4 boundary at count 8", dac_code, 1);

    // R2 hold without steps while comparator toggles
    for (int k = 0; k < 20; k++) begin
      cmp_above = ~cmp_above;
      @(negedge clk);
    end
    check("R2 hold without step", dac_code, 1);
    check("R7 rd_data layout", rd_data, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule